// File: doc/BRIEF.md
# Mode Pin Parameter Override Logic

This block works out the control settings that a clock synthesizer actually uses. It starts from a set of stored modal parameters and one general-purpose mode pin. A 3-bit pin-function code chooses what the pin does:

- It can switch off automatic choice of the fractional-N ratio source.
- It can drive the automatic ratio-modifier enable.
- It can choose the ratio source by hand.
- It can force the auxiliary output onto the PLL clock.

With any other code the pin is unused.

The fractional-N ratio source is either static (synthesizer mode) or dynamic (hybrid mode). When automatic selection is in force, the source follows a flag that says whether the input reference clock is present. Automatic selection always wins over a manual choice of source made through the pin.

The mode pin comes from off chip. It passes through a small synchronizer before any decision uses it. All other inputs are already in the clock domain and take effect combinationally.

Top module: `mode_pin_override`

## Requirements
- R1: A synchronous active-high reset clears the synchronized pin. While the reset is high, and until the pin has passed through the synchronizer, every output behaves as if the pin were low.
- R2: A change on the mode pin shows at the outputs after exactly two rising clock edges. Changes on the function code, the stored parameters or the clock-present flag show in the same cycle.
- R3: While automatic source selection is active, the ratio source output equals the clock-present flag: 1 (dynamic) when the clock is present, 0 (static) when it is absent.
- R4: With code 3'b100, automatic selection enabled and the pin high, automatic selection is switched off. The ratio source output then equals the stored source parameter, whatever the clock-present flag.
- R5: With code 3'b100 and automatic selection not enabled, the pin level changes no output.
- R6: With code 3'b101, the ratio-modifier enable output equals the synchronized pin: 0 disables it and 1 enables it. The stored value is not used.
- R7: With code 3'b110 and automatic selection not enabled, the ratio source output equals the synchronized pin: 0 is static, 1 is dynamic.
- R8: With code 3'b110 and automatic selection enabled, the pin is ignored and the ratio source output follows the clock-present flag.
- R9: With code 3'b111, a high pin forces the auxiliary source output to the PLL clock code 2'b10. A low pin passes the stored 2-bit auxiliary code through.
- R10: With codes 3'b000 to 3'b011 the pin is unused. The ratio source output is the clock-present flag if automatic selection is enabled, and the stored source otherwise. The other two outputs equal their stored values.
- R11: With any code other than 3'b101, the ratio-modifier output equals its stored value. With any code other than 3'b111, the auxiliary output equals its stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_func | input | 3 | Function code chosen for the mode pin |
| mode_pin | input | 1 | Asynchronous mode pin level |
| ref_present | input | 1 | High while the input reference clock is detected |
| cfg_auto_src_en | input | 1 | Stored enable for automatic ratio-source selection |
| cfg_ratio_src | input | 1 | Stored ratio source, 0 static, 1 dynamic |
| cfg_auto_rmod | input | 1 | Stored automatic ratio-modifier enable |
| cfg_aux_src | input | 2 | Stored auxiliary output source code |
| eff_ratio_src | output | 1 | Resolved ratio source, 0 static, 1 dynamic |
| eff_auto_rmod | output | 1 | Resolved ratio-modifier enable |
| eff_aux_src | output | 2 | Resolved auxiliary output source code |

## Verification
The bench sweeps all eight function codes against both pin levels. It also covers every value of the automatic-enable bit, the stored source, the clock-present flag, the stored modifier bit and all four auxiliary codes. For each case it waits for the pin to pass the synchronizer, then compares all three outputs with a model written from the requirements.

The sweep separates the cases that look alike from outside:
- code 3'b100 with automatic selection on and off (R4 against R5);
- code 3'b110 with automatic selection on and off (R8 against R7);
- codes where the pin counts against codes where it is unused.

Separate sequences check the reset value of the synchronized pin. They also check that the output holds after one edge and changes after the second.

// File: rtl/mpo_pkg.sv
package mpo_pkg;

    // Meaning given to the mode pin by the function code
    typedef enum logic [2:0] {
        PF_NONE0     = 3'b000,
        PF_NONE1     = 3'b001,
        PF_NONE2     = 3'b010,
        PF_NONE3     = 3'b011,
        PF_AUTO_OFF  = 3'b100,
        PF_RMOD      = 3'b101,
        PF_SRC_SEL   = 3'b110,
        PF_AUX_FORCE = 3'b111
    } pin_func_e;

    typedef enum logic {
        SRC_STATIC  = 1'b0,
        SRC_DYNAMIC = 1'b1
    } ratio_src_e;

    typedef struct packed {
        logic       auto_src_en;
        ratio_src_e ratio_src;
        logic       auto_rmod;
        logic [1:0] aux_src;
    } stored_cfg_t;

    typedef struct packed {
        ratio_src_e ratio_src;
        logic       auto_rmod;
        logic [1:0] aux_src;
    } eff_cfg_t;

    // One-hot view of which override the pin currently carries
    typedef struct packed {
        logic auto_off;
        logic rmod;
        logic src_sel;
        logic aux_force;
    } pin_role_t;

    function automatic pin_role_t decode_role(input logic [2:0] code);
        pin_role_t r;
        r = '0;
        case (code)
            PF_AUTO_OFF:  r.auto_off  = 1'b1;
            PF_RMOD:      r.rmod      = 1'b1;
            PF_SRC_SEL:   r.src_sel   = 1'b1;
            PF_AUX_FORCE: r.aux_force = 1'b1;
            default:      r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mpo_sync.sv
module mpo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int CW = $clog2(STAGES + 1);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    // Cycles since reset, used only to qualify the latency check
    logic [CW-1:0] settle;
    always_ff @(posedge clk) begin
        if (rst)                      settle <= '0;
        else if (settle != CW'(STAGES)) settle <= settle + 1'b1;
    end

    p_sync_clear_r1: assert property (@(posedge clk) rst |=> !q);

    generate
        if (STAGES == 2) begin : g_lat_chk
            p_pin_latency_r2: assert property (@(posedge clk) disable iff (rst)
                (settle == CW'(STAGES)) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/mpo_ratio_sel.sv
module mpo_ratio_sel
    import mpo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_role_t  role,
    input  logic       pin_s,
    input  logic       ref_present,
    input  logic       auto_src_en,
    input  ratio_src_e stored_src,
    output ratio_src_e ratio_src
);
    logic       auto_active;
    ratio_src_e manual_src;

    always_comb begin
        auto_active = auto_src_en && !(role.auto_off && pin_s);
        manual_src  = role.src_sel ? ratio_src_e'(pin_s) : stored_src;
        ratio_src   = auto_active ? ratio_src_e'(ref_present) : manual_src;
    end

    p_auto_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (auto_src_en && !(role.auto_off && pin_s)) |-> (ratio_src == ratio_src_e'(ref_present)));
    p_auto_off_r4: assert property (@(posedge clk) disable iff (rst)
        (auto_src_en && role.auto_off && pin_s) |-> (ratio_src == stored_src));
    p_manual_pin_r7: assert property (@(posedge clk) disable iff (rst)
        (!auto_src_en && role.src_sel) |-> (ratio_src == ratio_src_e'(pin_s)));
    p_stored_src_r10: assert property (@(posedge clk) disable iff (rst)
        (!auto_src_en && !role.src_sel) |-> (ratio_src == stored_src));

endmodule

// File: rtl/mpo_side_sel.sv
module mpo_side_sel
    import mpo_pkg::*;
#(
    parameter logic [1:0] AUX_PLL_CODE = 2'b10
) (
    input  logic       clk,
    input  logic       rst,
    input  pin_role_t  role,
    input  logic       pin_s,
    input  logic       stored_rmod,
    input  logic [1:0] stored_aux,
    output logic       auto_rmod,
    output logic [1:0] aux_src
);
    always_comb begin
        auto_rmod = role.rmod ? pin_s : stored_rmod;
        aux_src   = (role.aux_force && pin_s) ? AUX_PLL_CODE : stored_aux;
    end

    p_rmod_pin_r6: assert property (@(posedge clk) disable iff (rst)
        role.rmod |-> (auto_rmod == pin_s));
    p_rmod_keep_r11: assert property (@(posedge clk) disable iff (rst)
        !role.rmod |-> (auto_rmod == stored_rmod));
    p_aux_force_r9: assert property (@(posedge clk) disable iff (rst)
        (role.aux_force && pin_s) |-> (aux_src == AUX_PLL_CODE));
    p_aux_keep_r11: assert property (@(posedge clk) disable iff (rst)
        !(role.aux_force && pin_s) |-> (aux_src == stored_aux));

endmodule

// File: rtl/mode_pin_override.sv
module mode_pin_override
    import mpo_pkg::*;
#(
    parameter int         SYNC_STAGES  = 2,
    parameter logic [1:0] AUX_PLL_CODE = 2'b10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] pin_func,
    input  logic       mode_pin,
    input  logic       ref_present,
    input  logic       cfg_auto_src_en,
    input  logic       cfg_ratio_src,
    input  logic       cfg_auto_rmod,
    input  logic [1:0] cfg_aux_src,
    output logic       eff_ratio_src,
    output logic       eff_auto_rmod,
    output logic [1:0] eff_aux_src
);
    logic        pin_s;
    pin_role_t   role;
    stored_cfg_t stored;
    eff_cfg_t    eff;

    assign role   = decode_role(pin_func);
    assign stored = '{auto_src_en: cfg_auto_src_en,
                      ratio_src:   ratio_src_e'(cfg_ratio_src),
                      auto_rmod:   cfg_auto_rmod,
                      aux_src:     cfg_aux_src};

    mpo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mode_pin),
        .q   (pin_s)
    );

    mpo_ratio_sel u_ratio (
        .clk         (clk),
        .rst         (rst),
        .role        (role),
        .pin_s       (pin_s),
        .ref_present (ref_present),
        .auto_src_en (stored.auto_src_en),
        .stored_src  (stored.ratio_src),
        .ratio_src   (eff.ratio_src)
    );

    mpo_side_sel #(.AUX_PLL_CODE(AUX_PLL_CODE)) u_side (
        .clk         (clk),
        .rst         (rst),
        .role        (role),
        .pin_s       (pin_s),
        .stored_rmod (stored.auto_rmod),
        .stored_aux  (stored.aux_src),
        .auto_rmod   (eff.auto_rmod),
        .aux_src     (eff.aux_src)
    );

    assign eff_ratio_src = eff.ratio_src;
    assign eff_auto_rmod = eff.auto_rmod;
    assign eff_aux_src   = eff.aux_src;

    p_role_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({role.auto_off, role.rmod, role.src_sel, role.aux_force}));
    p_auto_off_inert_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_func == 3'b100 && !cfg_auto_src_en) |->
        (eff_ratio_src == cfg_ratio_src && eff_auto_rmod == cfg_auto_rmod
         && eff_aux_src == cfg_aux_src));
    p_src_pin_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (pin_func == 3'b110 && cfg_auto_src_en) |-> (eff_ratio_src == ref_present));

endmodule

// File: tb/sim_mode_pin_override.sv
module sim_mode_pin_override;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] pin_func;
    logic       mode_pin;
    logic       ref_present;
    logic       cfg_auto_src_en;
    logic       cfg_ratio_src;
    logic       cfg_auto_rmod;
    logic [1:0] cfg_aux_src;
    logic       eff_ratio_src;
    logic       eff_auto_rmod;
    logic [1:0] eff_aux_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mode_pin_override u0 (
        .clk             (clk),
        .rst             (rst),
        .pin_func        (pin_func),
        .mode_pin        (mode_pin),
        .ref_present     (ref_present),
        .cfg_auto_src_en (cfg_auto_src_en),
        .cfg_ratio_src   (cfg_ratio_src),
        .cfg_auto_rmod   (cfg_auto_rmod),
        .cfg_aux_src     (cfg_aux_src),
        .eff_ratio_src   (eff_ratio_src),
        .eff_auto_rmod   (eff_auto_rmod),
        .eff_aux_src     (eff_aux_src)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (func=%b pin=%b auto=%b src=%b ref=%b)",
                     tag, act, exp, pin_func, mode_pin, cfg_auto_src_en,
                     cfg_ratio_src, ref_present);
        end
    endtask

    initial begin
        rst = 1'b1; pin_func = 3'b101; mode_pin = 1'b1; ref_present = 1'b0;
        cfg_auto_src_en = 1'b0; cfg_ratio_src = 1'b0; cfg_auto_rmod = 1'b0;
        cfg_aux_src = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: in reset the pin reads low even though it is driven high
        check("R1", {1'b0, eff_auto_rmod}, 2'd0);
        pin_func = 3'b111;
        #1 check("R1", eff_aux_src, 2'b00);
        pin_func = 3'b101;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", {1'b0, eff_auto_rmod}, 2'd0);
        @(posedge clk); @(negedge clk);
        check("R2", {1'b0, eff_auto_rmod}, 2'd1);

        // R2: latency of pin changes
        mode_pin = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2", {1'b0, eff_auto_rmod}, 2'd1);
        @(posedge clk); @(negedge clk);
        check("R2", {1'b0, eff_auto_rmod}, 2'd0);
        // R2: the code acts in the same cycle
        pin_func = 3'b000; cfg_auto_rmod = 1'b1;
        #1 check("R2", {1'b0, eff_auto_rmod}, 2'd1);
        @(negedge clk);

        // Exhaustive sweep
        for (int v = 0; v < 1024; v++) begin
            logic [2:0] f;
            logic p, ae, cs, rp, rm;
            logic [1:0] ax;
            logic e_rs, e_rm, act_auto;
            logic [1:0] e_ax;
            string t_rs, t_rm, t_ax;
            f  = v[2:0]; p = v[3]; ae = v[4]; cs = v[5]; rp = v[6]; rm = v[7]; ax = v[9:8];
            pin_func = f; mode_pin = p; cfg_auto_src_en = ae; cfg_ratio_src = cs;
            ref_present = rp; cfg_auto_rmod = rm; cfg_aux_src = ax;
            @(posedge clk); @(posedge clk); @(negedge clk);
            act_auto = ae && !(f == 3'b100 && p);
            if (act_auto) begin
                e_rs = rp; t_rs = (f == 3'b110) ? "R8" : "R3";
            end else if (f == 3'b110) begin
                e_rs = p;  t_rs = "R7";
            end else begin
                e_rs = cs;
                t_rs = (f == 3'b100) ? (ae ? "R4" : "R5") : "R10";
            end
            e_rm = (f == 3'b101) ? p : rm;
            t_rm = (f == 3'b101) ? "R6" : ((f < 3'b100) ? "R10" : "R11");
            e_ax = (f == 3'b111 && p) ? 2'b10 : ax;
            t_ax = (f == 3'b111) ? "R9" : ((f == 3'b100 && !ae) ? "R5" : "R11");
            check(t_rs, {1'b0, eff_ratio_src}, {1'b0, e_rs});
            check(t_rm, {1'b0, eff_auto_rmod}, {1'b0, e_rm});
            check(t_ax, eff_aux_src, e_ax);
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule